// File: doc/BRIEF.md
# SPI Chip-Select Controller

This block generates the active-low chip-select lines of an SPI master. A small control register holds a two-bit line select, an ownership bit and a level bit. When ownership is manual, the level bit drives the selected line directly. When ownership is automatic, the block brackets each burst of the serial engine. It pulls the selected line low, waits one SPI clock period, and only then lets the engine start. After the engine reports its last edge, the block holds the line for another SPI clock period and then releases it.

The serial engine lies outside this block. It exchanges only three strobes with the controller: a burst request, a one-cycle start pulse produced here, and a one-cycle done pulse returned by the engine. Every line that is not selected stays high. When the selection moves from one asserted line to another, the block inserts one cycle with all lines high, so that two devices are never selected together.

Top module: `spi_cs_ctrl`

## Requirements
- R1: After synchronous reset, every `cs_n` bit is 1, `busy` and `eng_go` are 0, and `ctl_rdata` reads 8'hC0: level 1, owner 1, select 0.
- R2: A write to the control word stores level in bit 7, owner in bit 6 and select in bits 5:4. `ctl_rdata` returns these fields in the same positions, and all other bits read as 0.
- R3: With owner = 1 and no automatic burst running, level 0 pulls the selected line low and level 1 releases it. `cs_n` takes the new value at the same clock edge that samples the write.
- R4: At most one `cs_n` bit is ever low, and any low bit is the one chosen by the active select value.
- R5: A select value of NUM_CS or above asserts no line.
- R6: When an asserted line is replaced by a different one, `cs_n` is all ones for exactly one cycle before the new line falls.
- R7: With owner = 0 and the block idle, a burst request drives the selected line low at the edge that samples the request. Exactly SCLK_DIV cycles later, `eng_go` is high for a single cycle.
- R8: In an automatic burst, the line stays low for SCLK_DIV cycles after the edge that samples `eng_done`. It then rises, and `busy` drops at the same edge.
- R9: During an automatic burst, control-word writes update `ctl_rdata` but do not change `cs_n`. The select value captured at the request governs the whole burst.
- R10: With owner = 1, a burst request gives `eng_go` in the next cycle and leaves `cs_n` unchanged. `busy` stays high until `eng_done`.
- R11: A burst request that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control-word write strobe |
| ctl_wdata | input | 8 | Control word: [7] level, [6] owner, [5:4] select |
| ctl_rdata | output | 8 | Current control word |
| burst_req | input | 1 | Request to start a burst (one-cycle pulse) |
| eng_done | input | 1 | Engine finished its last edge (one-cycle pulse) |
| eng_go | output | 1 | Start pulse to the serial engine |
| busy | output | 1 | Burst in progress |
| cs_n | output | NUM_CS | Active-low chip-select lines |

## Verification
The bench builds the block with NUM_CS = 3 and SCLK_DIV = 3. With three lines, the two-bit select has one spare code, so the out-of-range select case can be reached. An SPI period of three cycles separates the lead and lag windows from an off-by-one count, and keeps the start pulse distinct from the request edge. Manual writes are applied from a vector table. The automatic and manual bursts are then checked cycle by cycle around the request, start and done strobes.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

    localparam int CTL_W     = 8;
    localparam int SEL_W     = 2;
    localparam int SEL_LSB   = 4;
    localparam int OWNER_BIT = 6;
    localparam int LEVEL_BIT = 7;

    typedef struct packed {
        logic             level;
        logic             owner;
        logic [SEL_W-1:0] sel;
    } cs_ctl_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LEAD = 2'd1,
        SEQ_RUN  = 2'd2,
        SEQ_LAG  = 2'd3
    } seq_state_e;

    localparam cs_ctl_t CTL_RESET = '{level: 1'b1, owner: 1'b1, sel: '0};

    function automatic cs_ctl_t ctl_unpack(input logic [CTL_W-1:0] w);
        cs_ctl_t c;
        c.level = w[LEVEL_BIT];
        c.owner = w[OWNER_BIT];
        c.sel   = w[SEL_LSB +: SEL_W];
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] ctl_pack(input cs_ctl_t c);
        logic [CTL_W-1:0] w;
        w                    = '0;
        w[LEVEL_BIT]         = c.level;
        w[OWNER_BIT]         = c.owner;
        w[SEL_LSB +: SEL_W]  = c.sel;
        return w;
    endfunction

endpackage

// File: rtl/cs_ctl_reg.sv
module cs_ctl_reg
    import spi_cs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output cs_ctl_t          ctl_q,
    output cs_ctl_t          ctl_d,
    output logic [CTL_W-1:0] rd_data
);

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en)
            ctl_d = ctl_unpack(wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= CTL_RESET;
        else
            ctl_q <= ctl_d;
    end

    assign rd_data = ctl_pack(ctl_q);

    // R1: the first cycle after reset shows the manual, inactive default
    p_reset_word_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data == 8'hC0));

endmodule

// File: rtl/cs_burst_seq.sv
module cs_burst_seq
    import spi_cs_pkg::*;
#(
    parameter int SCLK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             burst_req,
    input  logic             eng_done,
    input  logic             owner,
    input  logic [SEL_W-1:0] sel,
    output logic             eng_go,
    output logic             busy,
    output logic             auto_mode,
    output logic             auto_act_d,
    output logic [SEL_W-1:0] sel_act_d
);

    localparam int CNT_W = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SCLK_DIV - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             auto_q, auto_d;
    logic [SEL_W-1:0] sel_q, sel_d;
    logic             go_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        auto_d  = auto_q;
        sel_d   = sel_q;
        go_d    = 1'b0;
        case (state_q)
            SEQ_IDLE: begin
                if (burst_req) begin
                    auto_d = !owner;
                    sel_d  = sel;
                    cnt_d  = '0;
                    if (owner) begin
                        state_d = SEQ_RUN;
                        go_d    = 1'b1;
                    end else begin
                        state_d = SEQ_LEAD;
                    end
                end
            end
            SEQ_LEAD: begin
                if (cnt_q == CNT_LAST) begin
                    state_d = SEQ_RUN;
                    cnt_d   = '0;
                    go_d    = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            SEQ_RUN: begin
                if (eng_done) begin
                    cnt_d   = '0;
                    state_d = auto_q ? SEQ_LAG : SEQ_IDLE;
                end
            end
            SEQ_LAG: begin
                if (cnt_q == CNT_LAST)
                    state_d = SEQ_IDLE;
                else
                    cnt_d = cnt_q + 1'b1;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            auto_q  <= 1'b0;
            sel_q   <= '0;
            eng_go  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            auto_q  <= auto_d;
            sel_q   <= sel_d;
            eng_go  <= go_d;
        end
    end

    assign busy       = (state_q != SEQ_IDLE);
    assign auto_mode  = auto_q;
    assign auto_act_d = (state_d != SEQ_IDLE) && auto_d;
    assign sel_act_d  = sel_d;

    // R7: the start strobe lasts a single cycle
    p_go_single_r7: assert property (@(posedge clk) disable iff (rst)
        eng_go |=> !eng_go);

    // R10: a start strobe only appears inside a burst
    p_go_in_burst_r10: assert property (@(posedge clk) disable iff (rst)
        eng_go |-> busy);

endmodule

// File: rtl/cs_pin_drive.sv
module cs_pin_drive #(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CS-1:0] want,
    output logic [NUM_CS-1:0] cs_n
);

    logic [NUM_CS-1:0] held;
    logic              must_break;

    assign held       = ~cs_n;
    assign must_break = (held != '0) && (want != '0) && (want != held);

    always_ff @(posedge clk) begin
        if (rst)
            cs_n <= '1;
        else if (must_break)
            cs_n <= '1;
        else
            cs_n <= ~want;
    end

    // R4: never more than one device selected
    p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R6: a low line is never replaced directly by another low line
    p_break_r6: assert property (@(posedge clk) disable iff (rst)
        (($past(~cs_n) != '0) && ((~cs_n) != '0)) |-> ((~cs_n) == $past(~cs_n)));

endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl
    import spi_cs_pkg::*;
#(
    parameter int NUM_CS   = 4,
    parameter int SCLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_rdata,
    input  logic              burst_req,
    input  logic              eng_done,
    output logic              eng_go,
    output logic              busy,
    output logic [NUM_CS-1:0] cs_n
);

    cs_ctl_t           ctl_q, ctl_d;
    logic              auto_mode, auto_act_d;
    logic [SEL_W-1:0]  sel_act_d;
    logic              line_on;
    logic [SEL_W-1:0]  line_sel;
    logic [NUM_CS-1:0] want;

    cs_ctl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctl_we),
        .wr_data (ctl_wdata),
        .ctl_q   (ctl_q),
        .ctl_d   (ctl_d),
        .rd_data (ctl_rdata)
    );

    cs_burst_seq #(.SCLK_DIV(SCLK_DIV)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .burst_req  (burst_req),
        .eng_done   (eng_done),
        .owner      (ctl_q.owner),
        .sel        (ctl_q.sel),
        .eng_go     (eng_go),
        .busy       (busy),
        .auto_mode  (auto_mode),
        .auto_act_d (auto_act_d),
        .sel_act_d  (sel_act_d)
    );

    // An automatic burst overrides the manual fields; otherwise the
    // manual level applies only when software owns the lines.
    always_comb begin
        if (auto_act_d) begin
            line_on  = 1'b1;
            line_sel = sel_act_d;
        end else begin
            line_on  = ctl_d.owner && !ctl_d.level;
            line_sel = ctl_d.sel;
        end
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_dec
        assign want[i] = line_on && (line_sel == SEL_W'(i));
    end

    cs_pin_drive #(.NUM_CS(NUM_CS)) u_drv (
        .clk  (clk),
        .rst  (rst),
        .want (want),
        .cs_n (cs_n)
    );

    // R7: the engine is started only with a line already low
    p_lead_r7: assert property (@(posedge clk) disable iff (rst)
        (eng_go && auto_mode) |-> (cs_n != '1));

    // R8: the end of an automatic burst releases every line
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && $past(auto_mode)) |-> (cs_n == '1));

    // R9: lines are frozen while an automatic burst runs
    p_auto_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && auto_mode && $past(busy && auto_mode)) |-> $stable(cs_n));

endmodule

// File: tb/tb_spi_cs_ctrl.sv
module tb_spi_cs_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NCS        = 3;
    localparam int DIV        = 3;
    localparam int NVEC       = 9;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           ctl_we = 1'b0;
    logic [7:0]     ctl_wdata = '0;
    logic [7:0]     ctl_rdata;
    logic           burst_req = 1'b0;
    logic           eng_done = 1'b0;
    logic           eng_go;
    logic           busy;
    logic [NCS-1:0] cs_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cs_ctrl #(.NUM_CS(NCS), .SCLK_DIV(DIV)) dut (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .burst_req (burst_req),
        .eng_done  (eng_done),
        .eng_go    (eng_go),
        .busy      (busy),
        .cs_n      (cs_n)
    );

    // {write, wdata, expected cs_n, expected readback}
    localparam logic [19:0] VEC [0:NVEC-1] = '{
        {1'b1, 8'h40, 3'b110, 8'h40},  // R3 line 0 low
        {1'b1, 8'hC0, 3'b111, 8'hC0},  // R3 release
        {1'b1, 8'h50, 3'b101, 8'h50},  // R3 line 1 low
        {1'b1, 8'h60, 3'b111, 8'h60},  // R6 break cycle
        {1'b0, 8'h00, 3'b011, 8'h60},  // R6 line 2 follows
        {1'b1, 8'h70, 3'b111, 8'h70},  // R5 out-of-range select
        {1'b0, 8'h00, 3'b111, 8'h70},  // R5 stays released
        {1'b1, 8'h4F, 3'b110, 8'h40},  // R2 unused bits dropped
        {1'b1, 8'h00, 3'b111, 8'h00}   // R4 automatic owner, idle
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        chk("R1 cs_n", 32'(cs_n), 32'h7);
        chk("R1 rdata", 32'(ctl_rdata), 32'hC0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 go", 32'(eng_go), 0);

        for (int i = 0; i < NVEC; i++) begin
            ctl_we    = VEC[i][19];
            ctl_wdata = VEC[i][18:11];
            tick();
            ctl_we = 1'b0;
            chk($sformatf("R3/R5/R6 vec%0d cs_n", i), 32'(cs_n), 32'(VEC[i][10:8]));
            chk($sformatf("R2 vec%0d rdata", i), 32'(ctl_rdata), 32'(VEC[i][7:0]));
        end

        // R7 automatic burst on line 1
        ctl_we = 1'b1; ctl_wdata = 8'h10; tick(); ctl_we = 1'b0;
        chk("R4 auto idle cs_n", 32'(cs_n), 32'h7);
        burst_req = 1'b1; tick(); burst_req = 1'b0;
        chk("R7 cs_n at request", 32'(cs_n), 32'h5);
        chk("R7 busy", 32'(busy), 1);
        chk("R7 go early0", 32'(eng_go), 0);
        tick(); chk("R7 go early1", 32'(eng_go), 0);
        tick(); chk("R7 go early2", 32'(eng_go), 0);
        tick(); chk("R7 go on time", 32'(eng_go), 1);
        // R9/R11: write a new select and re-request while running
        ctl_we = 1'b1; ctl_wdata = 8'h20; burst_req = 1'b1;
        tick(); ctl_we = 1'b0; burst_req = 1'b0;
        chk("R7 go single", 32'(eng_go), 0);
        chk("R9 cs_n held", 32'(cs_n), 32'h5);
        chk("R9 rdata updated", 32'(ctl_rdata), 32'h20);
        tick();
        chk("R11 no restart", 32'(eng_go), 0);
        eng_done = 1'b1; tick(); eng_done = 1'b0;
        chk("R8 lag0 cs_n", 32'(cs_n), 32'h5);
        chk("R8 lag0 busy", 32'(busy), 1);
        tick(); chk("R8 lag1 cs_n", 32'(cs_n), 32'h5);
        tick(); chk("R8 lag2 cs_n", 32'(cs_n), 32'h5);
        tick();
        chk("R8 release cs_n", 32'(cs_n), 32'h7);
        chk("R8 busy drop", 32'(busy), 0);
        tick();
        chk("R11 no second burst", 32'(busy), 0);
        chk("R9 no assert after", 32'(cs_n), 32'h7);

        // R10 manual-owner burst
        ctl_we = 1'b1; ctl_wdata = 8'h50; tick(); ctl_we = 1'b0;
        chk("R3 manual line1", 32'(cs_n), 32'h5);
        burst_req = 1'b1; tick(); burst_req = 1'b0;
        chk("R10 go immediate", 32'(eng_go), 1);
        chk("R10 busy", 32'(busy), 1);
        chk("R10 cs_n kept", 32'(cs_n), 32'h5);
        tick();
        chk("R10 go single", 32'(eng_go), 0);
        chk("R10 still busy", 32'(busy), 1);
        eng_done = 1'b1; tick(); eng_done = 1'b0;
        chk("R10 busy drop", 32'(busy), 0);
        chk("R10 cs_n after", 32'(cs_n), 32'h5);

        // R1 reset while a line is held low
        rst = 1'b1; tick(); rst = 1'b0;
        chk("R1 reset cs_n", 32'(cs_n), 32'h7);
        chk("R1 reset rdata", 32'(ctl_rdata), 32'hC0);

        done = 1'b1;
        summary();
    end

endmodule